// File: doc/BRIEF.md
# Single-Wire Configuration Register Slave

This block is the slave end of an open-drain single-wire bus. It exists so that a bus master can load and inspect two 9-bit configuration words: a divider word and a mode word. The block runs on a fast sampling clock and synchronises the incoming line level. The master times every exchange through the length of its low pulses. The block pulls the line low only through its `pull_o` output. Outside logic turns that output into an open-drain driver.

A transaction has three parts. First the master holds the line low long enough for a bus reset. The slave then answers with a presence pulse. Next it takes an 8-bit command, least significant bit first. Last it moves exactly nine payload bits, also least significant bit first. The payload goes into the chosen register for a write command, or comes out of it for a read command. Every bit slot starts on a falling edge driven by the master. On a write slot the slave samples the line after a fixed delay. On a read slot the slave holds the line low for a fixed interval to send a 0, and leaves it alone to send a 1.

Once the payload is done, or after a command it does not know, the slave sits in a quiet state until the next bus reset. Setting both registers therefore takes two transactions. The state machine has ten named states:

- ST_IDLE: quiet, waiting for a bus reset.
- ST_RELEASE: reset seen, waiting for the line to rise.
- ST_PRES_GAP: delay before the presence pulse.
- ST_PRES_LOW: presence pulse being driven.
- ST_CMD_WAIT and ST_CMD_SLOT: command bits.
- ST_WR_WAIT and ST_WR_SLOT: write payload bits.
- ST_RD_WAIT and ST_RD_SLOT: read payload bits.

Each WAIT state moves to its SLOT state on a master falling edge. A SLOT state goes back to its WAIT state when its timer expires. The last bit of a phase moves on instead: the eighth command bit goes to a payload phase or to ST_IDLE, and the ninth payload bit goes to ST_IDLE. A detected bus reset sends every state to ST_RELEASE.

Top module: `cfgw_slave`

## Requirements
- R1: After `rst_n` is released, `div_o` is 9'h000, `mux_o` is 9'h034, `pull_o` is low and both strobes are low.
- R2: A low level that lasts RST_US microseconds (time = microseconds × CLK_PER_US clocks) is a bus reset, from any state. A low level much shorter than that, seen while idle, produces no presence pulse.
- R3: The presence pulse starts PRES_GAP_US after the line goes high at the end of a bus reset, and `pull_o` stays high for PRES_LEN_US.
- R4: The command byte is built from 8 slots, least significant bit first. Each bit is the line level SAMPLE_US after the master's falling edge (low = 0, high = 1).
- R5: Command 8'h01 writes the divider register. The 9 payload bits, least significant bit first, appear on `div_o`, and `div_wr_o` pulses for exactly one cycle after the ninth bit.
- R6: Command 8'h02 writes the mode register. Bits [5:0] of the payload are stored, bits [8:6] of `mux_o` always read 0, and `mux_wr_o` pulses for one cycle after the ninth bit.
- R7: Command 8'hA1 reads the divider register, least significant bit first. For a 0 bit the slave pulls the line low for RD_HOLD_US from the slot's falling edge. For a 1 bit the slave does not pull.
- R8: Command 8'hA2 reads the mode register in the same way as R7.
- R9: After the ninth payload bit, further slots do nothing until the next bus reset. There are no register changes, no strobes and no pull-down.
- R10: A command byte other than the four above is ignored until the next bus reset. The payload slots that follow change nothing and get no pull-down.
- R11: A bus reset in the middle of a transaction abandons it, and a new transaction follows normally.
- R12: The two write strobes are never high together, and neither is high for more than one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Sensed bus line level |
| pull_o | output | 1 | Pull the bus line low when high |
| div_o | output | 9 | Divider configuration register |
| mux_o | output | 9 | Mode configuration register, upper 3 bits always 0 |
| div_wr_o | output | 1 | One-cycle strobe when the divider register is written |
| mux_wr_o | output | 1 | One-cycle strobe when the mode register is written |

## Verification
The assertions assume a well-behaved master. It must hold each line level for several sampling clocks. It must never hold the line low across a sample point for long enough to look like a bus reset. It must leave the line high before each new falling edge. The bench meets these assumptions with a fixed slot of 70 microseconds:

- A write-0 holds the line low for 60.
- A write-1 holds it low for 5.
- A read starts with a 6-microsecond low and samples the line at 15.
- A bus reset holds the line low for 490.

The bench sweeps a set of payload patterns through write and read-back of both registers. It covers walking ones, all-zero, all-one and alternating patterns. It computes the stored mode value by masking off bits [8:6] in the bench.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    localparam int REG_W = 9;
    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_WR_DIV = 8'h01;
    localparam logic [CMD_W-1:0] OP_RD_DIV = 8'hA1;
    localparam logic [CMD_W-1:0] OP_WR_MUX = 8'h02;
    localparam logic [CMD_W-1:0] OP_RD_MUX = 8'hA2;

    localparam logic [REG_W-1:0] DIV_INIT = 9'h000;
    localparam logic [REG_W-1:0] MUX_INIT = 9'h034;
    localparam int               MUX_LIVE = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_PRES_GAP,
        ST_PRES_LOW,
        ST_CMD_WAIT,
        ST_CMD_SLOT,
        ST_WR_WAIT,
        ST_WR_SLOT,
        ST_RD_WAIT,
        ST_RD_SLOT
    } cfgw_state_e;

    typedef struct packed {
        logic valid;
        logic is_read;
        logic is_mux;
    } cfgw_op_t;

    function automatic cfgw_op_t decode_op(input logic [CMD_W-1:0] op);
        cfgw_op_t d;
        d = '0;
        unique case (op)
            OP_WR_DIV: d = '{valid: 1'b1, is_read: 1'b0, is_mux: 1'b0};
            OP_RD_DIV: d = '{valid: 1'b1, is_read: 1'b1, is_mux: 1'b0};
            OP_WR_MUX: d = '{valid: 1'b1, is_read: 1'b0, is_mux: 1'b1};
            OP_RD_MUX: d = '{valid: 1'b1, is_read: 1'b1, is_mux: 1'b1};
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cfgw_linesync.sv
module cfgw_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= line_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], line_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign line_s_o = chain_q[STAGES-1];
    assign fall_o   = prev_q & ~chain_q[STAGES-1];

    p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/cfgw_resetdet.sv
module cfgw_resetdet #(
    parameter int RST_CYC = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    output logic bus_rst_o
);
    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] low_cnt_q;
    logic          pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= !line_s && (low_cnt_q == CW'(RST_CYC - 1));
            if (line_s)
                low_cnt_q <= '0;
            else if (low_cnt_q != CW'(RST_CYC))
                low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign bus_rst_o = pulse_q;

    p_bus_rst_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_o |=> !bus_rst_o);

endmodule

// File: rtl/cfgw_regfile.sv
module cfgw_regfile
    import cfgw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_div_i,
    input  logic             wr_mux_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] div_o,
    output logic [REG_W-1:0] mux_o,
    output logic             div_stb_o,
    output logic             mux_stb_o
);
    localparam logic [REG_W-1:0] MUX_MASK = {{(REG_W-MUX_LIVE){1'b0}}, {MUX_LIVE{1'b1}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_o     <= DIV_INIT;
            mux_o     <= MUX_INIT;
            div_stb_o <= 1'b0;
            mux_stb_o <= 1'b0;
        end else begin
            div_stb_o <= wr_div_i;
            mux_stb_o <= wr_mux_i;
            if (wr_div_i) div_o <= wdata_i;
            if (wr_mux_i) mux_o <= wdata_i & MUX_MASK;
        end
    end

    p_div_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_div_i |=> (div_o == $past(wdata_i)) && div_stb_o);
    p_div_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_div_i |=> $stable(div_o) && !div_stb_o);
    p_mux_high_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mux_o[REG_W-1:MUX_LIVE] == '0);
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({div_stb_o, mux_stb_o}));

endmodule

// File: rtl/cfgw_slave.sv
module cfgw_slave
    import cfgw_pkg::*;
#(
    parameter int CLK_PER_US  = 16,
    parameter int RST_US      = 480,
    parameter int PRES_GAP_US = 30,
    parameter int PRES_LEN_US = 120,
    parameter int SAMPLE_US   = 30,
    parameter int RD_HOLD_US  = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    output logic             pull_o,
    output logic [REG_W-1:0] div_o,
    output logic [REG_W-1:0] mux_o,
    output logic             div_wr_o,
    output logic             mux_wr_o
);
    localparam int RST_CYC  = RST_US * CLK_PER_US;
    localparam int GAP_CYC  = PRES_GAP_US * CLK_PER_US;
    localparam int LEN_CYC  = PRES_LEN_US * CLK_PER_US;
    localparam int SAMP_CYC = SAMPLE_US * CLK_PER_US;
    localparam int HOLD_CYC = RD_HOLD_US * CLK_PER_US;
    localparam int MAX_AB   = (GAP_CYC > LEN_CYC) ? GAP_CYC : LEN_CYC;
    localparam int MAX_CD   = (SAMP_CYC > HOLD_CYC) ? SAMP_CYC : HOLD_CYC;
    localparam int MAX_CYC  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TMR_W    = $clog2(MAX_CYC + 1);
    localparam int CNT_W    = $clog2(REG_W + 1);

    logic line_s, fall, bus_rst;

    cfgw_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .line_s_o (line_s),
        .fall_o   (fall)
    );

    cfgw_resetdet #(.RST_CYC(RST_CYC)) u_rstdet (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .bus_rst_o (bus_rst)
    );

    cfgw_state_e       state_q, state_d;
    logic [TMR_W-1:0]  tmr_q;
    logic [CNT_W-1:0]  bit_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [REG_W-1:0]  shreg_q;
    logic              sel_mux_q;

    logic             tmr_samp, tmr_hold, tmr_gap, tmr_len;
    logic [CMD_W-1:0] cmd_full;
    logic [REG_W-1:0] pay_full;
    cfgw_op_t         op;
    logic             last_cmd_bit, last_pay_bit;
    logic             wr_div, wr_mux;

    assign tmr_samp     = (tmr_q == TMR_W'(SAMP_CYC - 1));
    assign tmr_hold     = (tmr_q == TMR_W'(HOLD_CYC - 1));
    assign tmr_gap      = (tmr_q == TMR_W'(GAP_CYC - 1));
    assign tmr_len      = (tmr_q == TMR_W'(LEN_CYC - 1));
    assign cmd_full     = {line_s, cmd_q[CMD_W-1:1]};
    assign pay_full     = {line_s, shreg_q[REG_W-1:1]};
    assign op           = decode_op(cmd_full);
    assign last_cmd_bit = (bit_q == CNT_W'(CMD_W - 1));
    assign last_pay_bit = (bit_q == CNT_W'(REG_W - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = ST_IDLE;
            ST_RELEASE:  if (line_s)   state_d = ST_PRES_GAP;
            ST_PRES_GAP: if (tmr_gap)  state_d = ST_PRES_LOW;
            ST_PRES_LOW: if (tmr_len)  state_d = ST_CMD_WAIT;
            ST_CMD_WAIT: if (fall)     state_d = ST_CMD_SLOT;
            ST_CMD_SLOT: if (tmr_samp) begin
                if (!last_cmd_bit)      state_d = ST_CMD_WAIT;
                else if (!op.valid)     state_d = ST_IDLE;
                else if (op.is_read)    state_d = ST_RD_WAIT;
                else                    state_d = ST_WR_WAIT;
            end
            ST_WR_WAIT:  if (fall)     state_d = ST_WR_SLOT;
            ST_WR_SLOT:  if (tmr_samp) state_d = last_pay_bit ? ST_IDLE : ST_WR_WAIT;
            ST_RD_WAIT:  if (fall)     state_d = ST_RD_SLOT;
            ST_RD_SLOT:  if (tmr_hold) state_d = last_pay_bit ? ST_IDLE : ST_RD_WAIT;
            default:                   state_d = ST_IDLE;
        endcase
        if (bus_rst) state_d = ST_RELEASE;
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tmr_q     <= '0;
            bit_q     <= '0;
            cmd_q     <= '0;
            shreg_q   <= '0;
            sel_mux_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                tmr_q <= '0;
            else if (state_q inside {ST_PRES_GAP, ST_PRES_LOW, ST_CMD_SLOT, ST_WR_SLOT, ST_RD_SLOT})
                tmr_q <= tmr_q + 1'b1;

            if (bus_rst) begin
                bit_q <= '0;
            end else begin
                unique case (state_q)
                    ST_CMD_SLOT: if (tmr_samp) begin
                        cmd_q <= cmd_full;
                        bit_q <= last_cmd_bit ? '0 : bit_q + 1'b1;
                        if (last_cmd_bit) begin
                            sel_mux_q <= op.is_mux;
                            shreg_q   <= op.is_mux ? mux_o : div_o;
                        end
                    end
                    ST_WR_SLOT: if (tmr_samp) begin
                        shreg_q <= pay_full;
                        bit_q   <= bit_q + 1'b1;
                    end
                    ST_RD_SLOT: if (tmr_hold) begin
                        shreg_q <= {1'b0, shreg_q[REG_W-1:1]};
                        bit_q   <= bit_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        pull_o = 1'b0;
        wr_div = 1'b0;
        wr_mux = 1'b0;
        unique case (state_q)
            ST_PRES_LOW: pull_o = 1'b1;
            ST_RD_SLOT:  pull_o = ~shreg_q[0];
            ST_WR_SLOT: if (tmr_samp && last_pay_bit && !bus_rst) begin
                wr_div = ~sel_mux_q;
                wr_mux = sel_mux_q;
            end
            default: ;
        endcase
    end

    cfgw_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_div_i  (wr_div),
        .wr_mux_i  (wr_mux),
        .wdata_i   (pay_full),
        .div_o     (div_o),
        .mux_o     (mux_o),
        .div_stb_o (div_wr_o),
        .mux_stb_o (mux_wr_o)
    );

    p_bus_rst_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> state_q == ST_RELEASE);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> !pull_o && !div_wr_o && !mux_wr_o);
    p_div_stb_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr_o |-> $past(state_q) == ST_WR_SLOT && $past(state_q, 1) != ST_IDLE);
    p_mux_stb_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mux_wr_o |-> $past(state_q) == ST_WR_SLOT);
    p_stb_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr_o || mux_wr_o) |=> !(div_wr_o || mux_wr_o));
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_o) |-> state_q inside {ST_PRES_LOW, ST_RD_SLOT});

endmodule

// File: tb/sim_cfgw_slave.sv
module sim_cfgw_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_pull = 1'b0;
    logic       line;
    logic       pull;
    logic [8:0] div_v, mux_v;
    logic       div_wr, mux_wr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int div_stb_cnt = 0, mux_stb_cnt = 0, both_hi = 0, wide = 0;
    logic [8:0] exp_div = 9'h000, exp_mux = 9'h034;

    always #5 clk = ~clk;
    assign line = ~(m_pull | pull);

    cfgw_slave #(.CLK_PER_US(1)) u0 (
        .clk(clk), .rst_n(rst_n), .line_i(line), .pull_o(pull),
        .div_o(div_v), .mux_o(mux_v), .div_wr_o(div_wr), .mux_wr_o(mux_wr)
    );

    logic prev_stb = 1'b0;
    always @(negedge clk) begin
        if (div_wr) div_stb_cnt++;
        if (mux_wr) mux_stb_cnt++;
        if (div_wr && mux_wr) both_hi++;
        if (prev_stb && (div_wr || mux_wr)) wide++;
        prev_stb <= div_wr | mux_wr;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bus reset plus presence measurement (R2, R3)
    task automatic bus_reset();
        m_pull = 1'b1; wait_n(490);
        m_pull = 1'b0; wait_n(20);
        chk(line === 1'b1, "R3 gap", line, 1);
        wait_n(25);
        chk(line === 1'b0, "R2/R3 presence start", line, 0);
        wait_n(95);
        chk(line === 1'b0, "R3 presence hold", line, 0);
        wait_n(30);
        chk(line === 1'b1, "R3 presence end", line, 1);
        wait_n(10);
    endtask

    task automatic wbit(input logic b);
        m_pull = 1'b1; wait_n(b ? 5 : 60);
        m_pull = 1'b0; wait_n(b ? 65 : 10);
    endtask

    task automatic rbit(output logic b);
        m_pull = 1'b1; wait_n(6);
        m_pull = 1'b0; wait_n(9);
        b = line;
        wait_n(55);
    endtask

    task automatic wbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wbit(v[i]);
    endtask

    task automatic wr_reg(input logic [7:0] op, input logic [8:0] v);
        bus_reset();
        div_stb_cnt = 0; mux_stb_cnt = 0;
        wbyte(op);
        for (int i = 0; i < 9; i++) wbit(v[i]);
        wait_n(5);
    endtask

    task automatic rd_reg(input logic [7:0] op, output logic [8:0] v);
        logic b;
        bus_reset();
        wbyte(op);
        for (int i = 0; i < 9; i++) begin
            rbit(b);
            v[i] = b;
        end
    endtask

    function automatic logic [8:0] div_pat(input int k);
        if (k < 9) return 9'(1 << k);
        case (k)
            9:  return 9'h000;
            10: return 9'h1FF;
            default: return 9'h155;
        endcase
    endfunction

    function automatic logic [8:0] mux_pat(input int k);
        case (k)
            0: return 9'h1FF;
            1: return 9'h000;
            2: return 9'h03F;
            3: return 9'h1C0;
            4: return 9'h015;
            5: return 9'h02A;
            default: return 9'h0C5;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [8:0] rv;
        logic b;
        int stb0;
        wait_n(5);
        chk(div_v === 9'h000, "R1 div reset", div_v, 0);
        chk(mux_v === 9'h034, "R1 mux reset", mux_v, 9'h034);
        chk(pull === 1'b0 && div_wr === 1'b0 && mux_wr === 1'b0, "R1 outputs idle",
            {pull, div_wr, mux_wr}, 0);
        rst_n = 1'b1;
        wait_n(5);

        // R2: short low while idle does not trigger presence
        begin
            int seen = 0;
            m_pull = 1'b1; wait_n(300);
            m_pull = 1'b0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (pull) seen++;
            end
            chk(seen == 0, "R2 short low ignored", seen, 0);
        end

        // R1/R8: default values read back
        rd_reg(8'hA2, rv);
        chk(rv === 9'h034, "R8 read mux default", rv, 9'h034);
        rd_reg(8'hA1, rv);
        chk(rv === 9'h000, "R7 read div default", rv, 0);

        // R4/R5/R7: divider sweep
        for (int k = 0; k < 12; k++) begin
            logic [8:0] v;
            v = div_pat(k);
            wr_reg(8'h01, v);
            exp_div = v;
            chk(div_v === exp_div, "R5 div write", div_v, exp_div);
            chk(div_stb_cnt == 1 && mux_stb_cnt == 0, "R5 div strobe", div_stb_cnt, 1);
            rd_reg(8'hA1, rv);
            chk(rv === exp_div, "R7 div read", rv, exp_div);
        end

        // R6/R8: mode sweep
        for (int k = 0; k < 7; k++) begin
            logic [8:0] v;
            v = mux_pat(k);
            wr_reg(8'h02, v);
            exp_mux = v & 9'h03F;
            chk(mux_v === exp_mux, "R6 mux write", mux_v, exp_mux);
            chk(mux_stb_cnt == 1 && div_stb_cnt == 0, "R6 mux strobe", mux_stb_cnt, 1);
            chk(div_v === exp_div, "R6 div untouched", div_v, exp_div);
            rd_reg(8'hA2, rv);
            chk(rv === exp_mux, "R8 mux read", rv, exp_mux);
        end

        // R9: slots after payload ignored
        wr_reg(8'h01, 9'h12D);
        exp_div = 9'h12D;
        for (int i = 0; i < 9; i++) wbit(1'b0);
        rbit(b);
        chk(div_v === exp_div, "R9 div after extra slots", div_v, exp_div);
        chk(div_stb_cnt == 1, "R9 no extra strobe", div_stb_cnt, 1);
        chk(b === 1'b1, "R9 no pull after payload", b, 1);

        // R10: unknown command ignored
        bus_reset();
        stb0 = div_stb_cnt + mux_stb_cnt;
        wbyte(8'h03);
        for (int i = 0; i < 9; i++) wbit(1'b1);
        rbit(b);
        chk(div_v === exp_div && mux_v === exp_mux, "R10 regs unchanged", div_v, exp_div);
        chk(div_stb_cnt + mux_stb_cnt == stb0, "R10 no strobe", div_stb_cnt + mux_stb_cnt, stb0);
        chk(b === 1'b1, "R10 no pull", b, 1);

        // R11: reset mid-transaction
        bus_reset();
        wbyte(8'h01);
        for (int i = 0; i < 4; i++) wbit(1'b1);
        wr_reg(8'h01, 9'h0AA);
        exp_div = 9'h0AA;
        chk(div_v === exp_div, "R11 restart write", div_v, exp_div);
        chk(div_stb_cnt == 1, "R11 single strobe", div_stb_cnt, 1);

        // R12: strobe shape over the whole run
        chk(both_hi == 0, "R12 strobes exclusive", both_hi, 0);
        chk(wide == 0, "R12 strobe width", wide, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule